// File: doc/BRIEF.md
# Dual-Channel Transmit Staging Buffer

This block stages outgoing frames for a network transmitter in two independent buffers, each holding 2048 bytes. Software uses a 32-bit register port. It first picks a channel and writes that channel's frame length. It then pushes frame data as 32-bit words. The shared data register always feeds whichever channel is currently selected, and each word is split into four bytes.

A control write to a channel then asks for that frame to be sent. This only works while the global transmit enable is set. The block reduces the requested length to the number of bytes the buffer actually holds. It then streams the frame one byte per clock over a valid/ready/last interface, which also reports the source channel.

When the final byte has been accepted, the channel's buffer and stored length are emptied and the channel's done flag is raised. The interrupt line is the OR of the done flags that are enabled in a mask register. Writing 1 to a done flag clears it.

Top module: `txq_dual_stage`

## Requirements
- R1: After reset, every readable register (enable 0x0, channel select 0x1, lengths 0x2/0x3, mask 0x7, status 0x8) reads 0, `tx_valid` is low and `irq` is low.
- R2: A write to address 0x1 stores 0 or 1 as given. Any value of 2 or more stores 0. The stored value reads back at 0x1.
- R3: A write to 0x4 appends the 32-bit value to the selected channel's buffer as four bytes, bits 7:0 first and bits 31:24 last.
- R4: When the selected buffer holds 2048 bytes, a write to 0x4 is discarded completely and the buffered data is unchanged.
- R5: A write to 0x2 (channel 0) or 0x3 (channel 1) stores the frame length. Values above 2048 are stored as 2048, and the stored value reads back.
- R6: A write to 0x5 (channel 0) or 0x6 (channel 1) requests a send only if write-data bit 0 is 1 and enable bit 0 at 0x0 is 1. Otherwise the write has no effect.
- R7: At request time, the length used is the smaller of the stored length and the bytes held. If that is 0, nothing is sent and no flag is set.
- R8: A requested frame begins on `tx_valid` in the cycle after the request, when the output is free. A byte is consumed on each clock where `tx_valid` and `tx_ready` are both high. Output holds while `tx_ready` is low. `tx_last` marks the final byte and `tx_chan` names the channel.
- R9: When a frame's final byte is consumed, that channel's buffer and stored length become empty. The channel's status bit is set: bit 0 for channel 0, bit 1 for channel 1.
- R10: `irq` is high exactly when (status & mask) is non-zero, where the mask is at 0x7 bits 1:0. Writing 0x8 clears each status bit written as 1. A flag being set in the same cycle wins over the clear.
- R11: Only one frame is on the output at a time. A request for a channel that is already waiting or sending is ignored. A request for the other channel waits and is sent after the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_valid | output | 1 | A frame byte is presented |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Presented byte is the final one of the frame |
| tx_chan | output | 1 | Channel the presented byte comes from |
| irq | output | 1 | Interrupt: enabled status bits non-zero |

## Verification
Suppose the buffer's fill count or the sender's byte position is wrong. That shows up on `tx_data` within one accepted byte, or as a missing or misplaced `tx_last`. A reference model compares every byte on every clock, so such a fault is reported the cycle it reaches the output.

Suppose the waiting-request state or the captured length is corrupted. Then a frame starts in the wrong cycle or with the wrong length, which is visible on `tx_valid` one cycle after the request. Errors in the status or mask registers reach `irq` in the same cycle they occur.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [3:0] {
    A_CFG   = 4'h0,
    A_CHSEL = 4'h1,
    A_LEN0  = 4'h2,
    A_LEN1  = 4'h3,
    A_PUSH  = 4'h4,
    A_GO0   = 4'h5,
    A_GO1   = 4'h6,
    A_MASK  = 4'h7,
    A_STAT  = 4'h8
  } reg_addr_e;
endpackage

// File: rtl/txq_word_fifo.sv
module txq_word_fifo #(
  parameter int unsigned DEPTH_W = 512,
  localparam int unsigned AW = $clog2(DEPTH_W),
  localparam int unsigned CW = $clog2(DEPTH_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [31:0]   data_i,
  input  logic          clr_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [31:0]   rd_word_o,
  output logic [CW-1:0] count_o
);
  logic [31:0]   mem_q [DEPTH_W];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (push_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i) mem_q[cnt_q[AW-1:0]] <= data_i;
  end

  assign rd_word_o = mem_q[rd_idx_i];
  assign count_o   = cnt_q;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CW'(DEPTH_W)));

  // R9
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/txq_sender.sv
module txq_sender #(
  parameter int unsigned LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    go_i,
  input  logic [LW-1:0] go_len_i,
  input  logic          ready_i,
  output logic          active_o,
  output logic          ch_o,
  output logic [LW-1:0] pos_o,
  output logic          last_o,
  output logic [1:0]    done_o
);
  logic [1:0]    pend_q, pend_d;
  logic [LW-1:0] plen_q [2];
  logic [LW-1:0] plen_d [2];
  logic          act_q, act_d, ch_q, ch_d;
  logic [LW-1:0] alen_q, alen_d, pos_q, pos_d;
  logic [1:0]    busy;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      busy[c]   = pend_q[c] | (act_q & (ch_q == 1'(c)));
      done_o[c] = act_q & ready_i & last_o & (ch_q == 1'(c));
    end
  end

  assign last_o = act_q && (pos_q == alen_q - LW'(1));

  always_comb begin
    pend_d = pend_q;
    plen_d = plen_q;
    act_d  = act_q;
    ch_d   = ch_q;
    alen_d = alen_q;
    pos_d  = pos_q;
    if (act_q) begin
      if (ready_i) begin
        if (last_o) act_d = 1'b0;
        else        pos_d = pos_q + LW'(1);
      end
    end else if (|pend_q) begin
      ch_d         = ~pend_q[0];
      act_d        = 1'b1;
      pos_d        = '0;
      alen_d       = pend_q[0] ? plen_q[0] : plen_q[1];
      pend_d[ch_d] = 1'b0;
    end
    for (int c = 0; c < 2; c++) begin
      if (go_i[c] && !busy[c]) begin
        pend_d[c] = 1'b1;
        plen_d[c] = go_len_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= 1'b0;
      ch_q   <= 1'b0;
      alen_q <= '0;
      pos_q  <= '0;
      for (int c = 0; c < 2; c++) plen_q[c] <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      ch_q   <= ch_d;
      alen_q <= alen_d;
      pos_q  <= pos_d;
      plen_q <= plen_d;
    end
  end

  assign active_o = act_q;
  assign ch_o     = ch_q;
  assign pos_o    = pos_q;

  // R8
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !ready_i) |=> (act_q && $stable(pos_q) && $stable(ch_q)));

  // R11
  pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !pend_q[ch_q]);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (alen_q != '0));
endmodule

// File: rtl/txq_irq.sv
module txq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_i,
  input  logic       mask_we_i,
  input  logic       clr_we_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] sts_o,
  output logic [1:0] mask_o,
  output logic       irq_o
);
  logic [1:0] sts_q, sts_d, mask_q, mask_d;

  always_comb begin
    sts_d  = (sts_q & ~(clr_we_i ? wdata_i : 2'b00)) | set_i;
    mask_d = mask_we_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
    end
  end

  assign irq_o  = |(sts_q & mask_q);
  assign sts_o  = sts_q;
  assign mask_o = mask_q;

  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && wdata_i == 2'b11 && set_i == 2'b00) |=> !irq_o);
endmodule

// File: rtl/txq_dual_stage.sv
module txq_dual_stage #(
  parameter int unsigned FIFO_BYTES = 2048,
  localparam int unsigned DEPTH_W = FIFO_BYTES / 4,
  localparam int unsigned AW = $clog2(DEPTH_W),
  localparam int unsigned CW = $clog2(DEPTH_W + 1),
  localparam int unsigned LW = $clog2(FIFO_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_chan,
  output logic        irq
);
  import txq_pkg::*;

  logic          en_q, en_d, sel_q, sel_d;
  logic [LW-1:0] len_q [NCH];
  logic [LW-1:0] len_d [NCH];
  logic [LW-1:0] held  [NCH];
  logic [CW-1:0] cnt   [NCH];
  logic [31:0]   word  [NCH];
  logic [1:0]    push, go, done, wr_len, wr_go, sts, mask;
  logic          wr_push, go_ch;
  logic [LW-1:0] wlen, eff, pos;
  logic [31:0]   cur_word;

  assign wr_push   = reg_we && (reg_addr == A_PUSH);
  assign wr_len[0] = reg_we && (reg_addr == A_LEN0);
  assign wr_len[1] = reg_we && (reg_addr == A_LEN1);
  assign wr_go[0]  = reg_we && (reg_addr == A_GO0);
  assign wr_go[1]  = reg_we && (reg_addr == A_GO1);
  assign go_ch     = wr_go[1];
  assign wlen      = (reg_wdata > 32'(FIFO_BYTES)) ? LW'(FIFO_BYTES) : reg_wdata[LW-1:0];
  assign eff       = (len_q[go_ch] > held[go_ch]) ? held[go_ch] : len_q[go_ch];

  always_comb begin
    en_d  = (reg_we && reg_addr == A_CFG) ? reg_wdata[0] : en_q;
    sel_d = sel_q;
    if (reg_we && reg_addr == A_CHSEL) sel_d = (reg_wdata < 32'd2) ? reg_wdata[0] : 1'b0;
    for (int c = 0; c < NCH; c++) begin
      held[c]  = LW'({cnt[c], 2'b00});
      push[c]  = wr_push && (sel_q == 1'(c)) && (cnt[c] < CW'(DEPTH_W));
      go[c]    = wr_go[c] && reg_wdata[0] && en_q && (eff != '0);
      len_d[c] = len_q[c];
      if (done[c])        len_d[c] = '0;
      else if (wr_len[c]) len_d[c] = wlen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      for (int c = 0; c < NCH; c++) len_q[c] <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
      len_q <= len_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_buf
    txq_word_fifo #(.DEPTH_W(DEPTH_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push[g]),
      .data_i    (reg_wdata),
      .clr_i     (done[g]),
      .rd_idx_i  (pos[AW+1:2]),
      .rd_word_o (word[g]),
      .count_o   (cnt[g])
    );
  end

  txq_sender #(.LW(LW)) u_send (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go),
    .go_len_i (eff),
    .ready_i  (tx_ready),
    .active_o (tx_valid),
    .ch_o     (tx_chan),
    .pos_o    (pos),
    .last_o   (tx_last),
    .done_o   (done)
  );

  txq_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (done),
    .mask_we_i (reg_we && reg_addr == A_MASK),
    .clr_we_i  (reg_we && reg_addr == A_STAT),
    .wdata_i   (reg_wdata[1:0]),
    .sts_o     (sts),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  assign cur_word = tx_chan ? word[1] : word[0];
  assign tx_data  = cur_word[{pos[1:0], 3'b000} +: 8];

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {31'd0, en_q};
      A_CHSEL: reg_rdata = {31'd0, sel_q};
      A_LEN0:  reg_rdata = 32'(len_q[0]);
      A_LEN1:  reg_rdata = 32'(len_q[1]);
      A_MASK:  reg_rdata = {30'd0, mask};
      A_STAT:  reg_rdata = {30'd0, sts};
      default: reg_rdata = '0;
    endcase
  end

  // R5
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q[0] <= LW'(FIFO_BYTES)) && (len_q[1] <= LW'(FIFO_BYTES)));
endmodule

// File: tb/txq_dual_stage_tb_top.sv
module txq_dual_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_last, tx_chan, irq;
  logic [7:0]  tx_data;
  logic        rdy_force = 1'b1, rdy_pat = 1'b0;
  logic        tx_ready;
  int unsigned cyc = 0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  always @(negedge clk) cyc <= cyc + 1;
  assign tx_ready = rdy_force | (rdy_pat && (cyc % 3 != 0));

  txq_dual_stage dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_chan(tx_chan), .irq(irq)
  );

  // reference model
  logic [7:0] mq0[$];
  logic [7:0] mq1[$];
  int  m_len [2];
  int  m_plen [2];
  bit  m_pend [2];
  int  m_act = -1, m_alen = 0, m_pos = 0;
  bit  m_en = 0, m_sel = 0;
  bit [1:0] m_mask = 0, m_sts = 0;

  function automatic int qsize(int c);
    return (c == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic logic [7:0] qget(int c, int i);
    return (c == 0) ? mq0[i] : mq1[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq0.delete(); mq1.delete();
      m_len[0] = 0; m_len[1] = 0; m_pend[0] = 0; m_pend[1] = 0;
      m_act = -1; m_en = 0; m_sel = 0; m_mask = 0; m_sts = 0;
    end else begin
      int  done_c;
      bit  busy [2];
      done_c = -1;
      for (int c = 0; c < 2; c++) busy[c] = m_pend[c] || (m_act == c);
      if (m_act >= 0) begin
        if (tx_ready) begin
          if (m_pos == m_alen - 1) begin done_c = m_act; m_act = -1; end
          else m_pos++;
        end
      end else if (m_pend[0] || m_pend[1]) begin
        m_act = m_pend[0] ? 0 : 1;
        m_alen = m_plen[m_act]; m_pos = 0; m_pend[m_act] = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          4'h0: m_en = reg_wdata[0];
          4'h1: m_sel = (reg_wdata < 2) ? reg_wdata[0] : 1'b0;
          4'h2, 4'h3: m_len[reg_addr - 2] = (reg_wdata > 2048) ? 2048 : int'(reg_wdata);
          4'h4: if (qsize(m_sel) <= 2044) begin
            for (int b = 0; b < 4; b++) begin
              if (m_sel == 0) mq0.push_back(reg_wdata[8*b +: 8]);
              else            mq1.push_back(reg_wdata[8*b +: 8]);
            end
          end
          4'h5, 4'h6: begin
            int c, e;
            c = reg_addr - 5;
            e = (m_len[c] > qsize(c)) ? qsize(c) : m_len[c];
            if (reg_wdata[0] && m_en && e > 0 && !busy[c]) begin
              m_pend[c] = 1; m_plen[c] = e;
            end
          end
          4'h7: m_mask = reg_wdata[1:0];
          4'h8: m_sts = m_sts & ~reg_wdata[1:0];
          default: ;
        endcase
      end
      if (done_c >= 0) begin
        if (done_c == 0) mq0.delete(); else mq1.delete();
        m_len[done_c] = 0;
        m_sts[done_c] = 1'b1;
      end
    end
  end

  // per-cycle comparison (R8, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = (m_act >= 0);
      checks++;
      if (tx_valid !== ev) begin
        errors++; $display("FAIL R8 tx_valid act=%0b exp=%0b cyc=%0d", tx_valid, ev, cyc);
      end else if (ev) begin
        if (tx_data !== qget(m_act, m_pos) || tx_last !== (m_pos == m_alen - 1) || tx_chan !== 1'(m_act)) begin
          errors++;
          $display("FAIL R8 byte act=%h/%0b/%0b exp=%h/%0b/%0b cyc=%0d", tx_data, tx_last, tx_chan,
                   qget(m_act, m_pos), (m_pos == m_alen - 1), 1'(m_act), cyc);
        end
      end
      checks++;
      if (irq !== |(m_sts & m_mask)) begin
        errors++; $display("FAIL R10 irq act=%0b exp=%0b cyc=%0d", irq, |(m_sts & m_mask), cyc);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++; $display("FAIL %s addr %0h act=%0h exp=%0h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic wait_idle();
    while (m_act >= 0 || m_pend[0] || m_pend[1]) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(4'h0, 0, "R1"); rd_chk(4'h1, 0, "R1"); rd_chk(4'h2, 0, "R1");
    rd_chk(4'h3, 0, "R1"); rd_chk(4'h7, 0, "R1"); rd_chk(4'h8, 0, "R1");
    checks++;
    if (tx_valid !== 1'b0 || irq !== 1'b0) begin
      errors++; $display("FAIL R1 valid/irq act=%0b/%0b exp=0/0", tx_valid, irq);
    end
    // R2 channel select
    wr(4'h1, 1); rd_chk(4'h1, 1, "R2");
    wr(4'h1, 5); rd_chk(4'h1, 0, "R2");
    wr(4'h1, 1); wr(4'h1, 2); rd_chk(4'h1, 0, "R2");
    // R5 length clamp
    wr(4'h2, 5000); rd_chk(4'h2, 2048, "R5");
    wr(4'h2, 2049); rd_chk(4'h2, 2048, "R5");
    wr(4'h2, 7); rd_chk(4'h2, 7, "R5");
    // R6 request blocked when disabled or bit0 clear
    wr(4'h4, 32'h4433_2211); wr(4'h4, 32'h8877_6655);
    wr(4'h5, 1); repeat (4) @(negedge clk);
    wr(4'h0, 1); wr(4'h5, 2); repeat (4) @(negedge clk);
    rd_chk(4'h8, 0, "R6"); rd_chk(4'h2, 7, "R6");
    // R3 R8 R9 send 7 of 8 bytes with stalls
    rdy_force = 1'b0; rdy_pat = 1'b1;
    wr(4'h5, 1); wait_idle(); @(negedge clk);
    rdy_force = 1'b1; rdy_pat = 1'b0;
    rd_chk(4'h8, 1, "R9"); rd_chk(4'h2, 0, "R9");
    // R7 held bytes zero -> nothing, no status change
    wr(4'h2, 4); wr(4'h8, 1); wr(4'h5, 1); repeat (4) @(negedge clk);
    rd_chk(4'h8, 0, "R7");
    // R10 mask and W1C
    wr(4'h1, 1); wr(4'h3, 100);
    wr(4'h4, 32'hDEAD_BEEF); wr(4'h4, 32'h0102_0304); wr(4'h4, 32'hCAFE_F00D);
    wr(4'h7, 2); wr(4'h6, 1); wait_idle(); @(negedge clk);
    rd_chk(4'h8, 2, "R10");
    wr(4'h8, 1); rd_chk(4'h8, 2, "R10");
    wr(4'h8, 2); rd_chk(4'h8, 0, "R10");
    // R11 one frame at a time, repeat ignored, other channel waits
    wr(4'h7, 3);
    wr(4'h1, 0);
    for (int i = 0; i < 10; i++) wr(4'h4, 32'h1111_1111 * (i + 1));
    wr(4'h2, 40);
    wr(4'h1, 1); wr(4'h4, 32'hA1B2_C3D4); wr(4'h4, 32'h5566_7788); wr(4'h3, 8);
    rdy_force = 1'b0;
    wr(4'h5, 1); wr(4'h6, 1); wr(4'h5, 1); wr(4'h6, 1);
    rdy_force = 1'b1;
    wait_idle(); @(negedge clk);
    rd_chk(4'h8, 3, "R11");
    wr(4'h8, 3);
    // R4 overrun: 513 pushes, last dropped
    wr(4'h1, 0);
    for (int i = 0; i < 513; i++) wr(4'h4, 32'h1000_0000 + i * 32'h0001_0203);
    wr(4'h2, 9999); rd_chk(4'h2, 2048, "R4");
    wr(4'h5, 1); wait_idle(); @(negedge clk);
    rd_chk(4'h8, 1, "R4");
    rd_chk(4'h2, 0, "R9");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule